// File: doc/BRIEF.md
# Chaotic 128-bit Permutation Unit

This unit scrambles a 128-bit operand `a_i` through four quarter rounds of a nonlinear, invertible mixer and then XORs a second 128-bit operand `b_i` into the result. Each quarter round XORs in a round key, shuffles the sixteen bytes and runs three OR-based bit-mixing steps on each 64-bit lane. The unit suits use as a general mixing primitive: `b_i` carries key material or a neighbouring state, and because `b_i` enters after the mixing, the mapping b -> f(a, b) undoes itself inside a Feistel structure.

All four rounds sit in one combinational cone. A parameter selects whether the result is captured in an output register, which is the default, or passed straight through. There is no handshake: a new operand pair may be presented every cycle.

Top module: `chaos_perm128`

## Requirements
- R1: With `REG_OUT`=1, `y_o` shows the result for the `a_i`/`b_i` pair sampled at the previous rising edge of `clk_i`. `y_o` is all zeros while `rst_ni` is low, and it stays zero until the first rising edge after release.
- R2: Every round begins by XORing in a 128-bit key. The lower lane is bits [63:0] and the upper lane is bits [127:64]. Rounds 1, 2 and 4 XOR 0x13198A2E03707344 into both lanes. Round 3 XORs 0x243F6A8885A308D3 into the upper lane and 0x13198A2E03707344 into the lower lane.
- R3: After the key step, byte k (bits [8k+7:8k]) of the state takes input byte (5k+3) mod 16.
- R4: After the byte step, three mixing steps act on each lane, using logical shifts that fill with zeros. A left step with distance d computes x ^ (((x<<1)|(x<<2)) ^ (x<<d)), and a right step is the same with >>. The three steps are left 4, then right 10, then left 7.
- R5: `b_i` is XORed in only after round 4. So f(a,b) ^ f(a,0) equals b, and f(a, f(a,b)) equals b.
- R6: For a nonzero operand, swapping the two lanes of `a_i` does not just swap the lanes of the result: f(swap(a),0) differs from swap(f(a,0)).
- R7: Flipping any single bit of `a_i` changes between 20 and 108 bits of `y_o`. Averaged over sixteen such flips, the count is between 52 and 76.
- R8: While `a_i` and `b_i` stay constant, `y_o` stays constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | 128 | Operand passed through the four rounds |
| b_i | input | 128 | Operand XORed in after the rounds |
| y_o | output | 128 | Result, registered when REG_OUT=1 |

## Verification
The only internal state is the output register, and a wrong value there shows on `y_o` in the cycle after the operands were sampled. A fault inside the round cone has no state to hide in. The avalanche property means almost any wrong key bit, byte source or shift tap disturbs about half of the 128 output bits of the next result, so a comparison against an independent bit-level model catches it on the first vector. Faults in the ordering of the `b_i` XOR show up as a broken linearity of `y_o` in `b_i`, which both the bench and a clocked property check from cycle to cycle.

// File: rtl/cp_pkg.sv
package cp_pkg;
    localparam int LANE_W  = 64;
    localparam int N_LANES = 2;
    localparam int BLK_W   = LANE_W * N_LANES;
    localparam int N_BYTES = BLK_W / 8;
    localparam int N_ROUNDS = 4;
    localparam int ALT_ROUND = 2;          // zero-based index of the asymmetric round

    localparam logic [LANE_W-1:0] KEY_BASE = 64'h13198A2E03707344;
    localparam logic [LANE_W-1:0] KEY_ALT  = 64'h243F6A8885A308D3;

    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        blk_t res;
    } cp_state_t;

    function automatic blk_t round_key(input int ridx);
        blk_t k;
        k[LANE_W-1:0]     = KEY_BASE;
        k[BLK_W-1:LANE_W] = (ridx == ALT_ROUND) ? KEY_ALT : KEY_BASE;
        return k;
    endfunction
endpackage

// File: rtl/cp_byteperm.sv
module cp_byteperm #(
    parameter int N_BYTES = 16,
    parameter int MUL     = 5,
    parameter int ADD     = 3
) (
    input  logic [N_BYTES*8-1:0] x_i,
    output logic [N_BYTES*8-1:0] x_o
);
    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        localparam int SRC = (MUL * k + ADD) % N_BYTES;
        assign x_o[8*k +: 8] = x_i[8*SRC +: 8];
    end
endmodule

// File: rtl/cp_bitmix.sv
module cp_bitmix #(
    parameter int LANE_W  = 64,
    parameter int N_LANES = 2,
    parameter int DIST    = 4,
    parameter bit LEFT    = 1'b1
) (
    input  logic [LANE_W*N_LANES-1:0] x_i,
    output logic [LANE_W*N_LANES-1:0] x_o
);
    for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
        logic [LANE_W-1:0] v;
        logic [LANE_W-1:0] near_or;
        logic [LANE_W-1:0] far;
        assign v = x_i[LANE_W*ln +: LANE_W];
        if (LEFT) begin : g_left
            assign near_or = (v << 1) | (v << 2);
            assign far     = v << DIST;
        end else begin : g_right
            assign near_or = (v >> 1) | (v >> 2);
            assign far     = v >> DIST;
        end
        assign x_o[LANE_W*ln +: LANE_W] = v ^ near_or ^ far;
    end
endmodule

// File: rtl/cp_qround.sv
module cp_qround
    import cp_pkg::*;
#(
    parameter int RIDX = 0
) (
    input  blk_t s_i,
    output blk_t s_o
);
    localparam blk_t KEY = round_key(RIDX);

    blk_t keyed_w;
    blk_t shuf_w;
    blk_t m1_w;
    blk_t m2_w;

    assign keyed_w = s_i ^ KEY;

    cp_byteperm #(.N_BYTES(N_BYTES), .MUL(5), .ADD(3)) u_perm (
        .x_i(keyed_w), .x_o(shuf_w));

    cp_bitmix #(.LANE_W(LANE_W), .N_LANES(N_LANES), .DIST(4), .LEFT(1'b1)) u_mix_a (
        .x_i(shuf_w), .x_o(m1_w));
    cp_bitmix #(.LANE_W(LANE_W), .N_LANES(N_LANES), .DIST(10), .LEFT(1'b0)) u_mix_b (
        .x_i(m1_w), .x_o(m2_w));
    cp_bitmix #(.LANE_W(LANE_W), .N_LANES(N_LANES), .DIST(7), .LEFT(1'b1)) u_mix_c (
        .x_i(m2_w), .x_o(s_o));
endmodule

// File: rtl/chaos_perm128.sv
module chaos_perm128
    import cp_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [BLK_W-1:0] a_i,
    input  logic [BLK_W-1:0] b_i,
    output logic [BLK_W-1:0] y_o
);
    blk_t      chain_w [N_ROUNDS+1];
    blk_t      mix_w;
    cp_state_t state_d;
    cp_state_t state_q;

    assign chain_w[0] = a_i;

    for (genvar r = 0; r < N_ROUNDS; r++) begin : g_round
        cp_qround #(.RIDX(r)) u_round (
            .s_i(chain_w[r]),
            .s_o(chain_w[r+1])
        );
    end

    assign mix_w = chain_w[N_ROUNDS];

    always_comb begin
        state_d     = state_q;
        state_d.res = mix_w ^ b_i;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) state_q <= '0;
            else         state_q <= state_d;
        end
    end else begin : g_comb
        always_comb state_q = state_d;
    end

    assign y_o = state_q.res;
endmodule

// File: rtl/chaos_perm128_chk.sv
module chaos_perm128_chk #(
    parameter bit REG_OUT = 1'b1,
    parameter int W       = 128
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [W-1:0] mix_i,
    input logic [W-1:0] y_o
);
    logic [1:0] age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    if (REG_OUT) begin : g_props
        // R1: output clear at the first edge after reset release
        a_r1_reset_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (age_q == 2'd0) |-> (y_o == '0));

        // R1: output is the round result combined with b one cycle later
        a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (age_q != 2'd0) |=> (y_o == $past(mix_i ^ b_i)));

        // R8: held operands give a held output
        a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (age_q >= 2'd1 && $stable(a_i) && $stable(b_i)) |=> $stable(y_o));

        // R5: with a fixed, output changes exactly by the change in b
        a_r5_b_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (age_q >= 2'd1 && $stable(a_i)) |=>
                ((y_o ^ $past(y_o)) == ($past(b_i) ^ $past(b_i, 2))));
    end
endmodule

bind chaos_perm128 chaos_perm128_chk #(.REG_OUT(REG_OUT), .W(cp_pkg::BLK_W)) chk_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (a_i),
    .b_i   (b_i),
    .mix_i (mix_w),
    .y_o   (y_o)
);

// File: tb/chaos_perm128_tb_top.sv
module chaos_perm128_tb_top;
    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic [127:0] a_i = '0;
    logic [127:0] b_i = '0;
    logic [127:0] y_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    chaos_perm128 #(.REG_OUT(1'b1)) dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .y_o(y_o));

    localparam int NV = 8;
    localparam logic [255:0] VEC [NV] = '{
        {128'h0, 128'h0},
        {128'h1, 128'h0},
        {128'h8000_0000_0000_0000_0000_0000_0000_0000, 128'h0},
        {128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 128'h0},
        {128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555},
        {128'h243F_6A88_85A3_08D3_1319_8A2E_0370_7344, 128'h0},
        {128'h1319_8A2E_0370_7344_1319_8A2E_0370_7344, 128'hFFFF_0000_FFFF_0000_FFFF_0000_FFFF_0000},
        {128'hA5A5_5A5A_0F0F_F0F0_3C3C_C3C3_9696_6969, 128'h0000_0000_0000_0001_8000_0000_0000_0000}
    };

    // Bit-level model written from R2..R5
    function automatic logic [127:0] gold(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] s;
        s = a;
        for (int r = 0; r < 4; r++) begin
            logic [127:0] t;
            s[63:0]   = s[63:0] ^ 64'h13198A2E03707344;
            s[127:64] = s[127:64] ^ ((r == 2) ? 64'h243F6A8885A308D3 : 64'h13198A2E03707344);
            for (int k = 0; k < 16; k++) t[8*k +: 8] = s[8*((5*k+3) % 16) +: 8];
            s = t;
            for (int ln = 0; ln < 2; ln++) begin
                logic [63:0] l;
                l = s[64*ln +: 64];
                for (int st = 0; st < 3; st++) begin
                    logic [63:0] n;
                    int d;
                    bit lf;
                    d  = (st == 0) ? 4 : (st == 1) ? 10 : 7;
                    lf = (st != 1);
                    for (int j = 0; j < 64; j++) begin
                        logic p1, p2, pf;
                        if (lf) begin
                            p1 = (j >= 1) ? l[(j+63) % 64] : 1'b0;
                            p2 = (j >= 2) ? l[(j+62) % 64] : 1'b0;
                            pf = (j >= d) ? l[(j+64-d) % 64] : 1'b0;
                        end else begin
                            p1 = (j <= 62) ? l[(j+1) % 64] : 1'b0;
                            p2 = (j <= 61) ? l[(j+2) % 64] : 1'b0;
                            pf = (j + d <= 63) ? l[(j+d) % 64] : 1'b0;
                        end
                        n[j] = l[j] ^ (p1 | p2) ^ pf;
                    end
                    l = n;
                end
                s[64*ln +: 64] = l;
            end
        end
        return s ^ b;
    endfunction

    function automatic logic [127:0] swp(input logic [127:0] v);
        return {v[63:0], v[127:64]};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [127:0] a, input logic [127:0] b, output logic [127:0] y);
        @(negedge clk_i);
        a_i = a;
        b_i = b;
        @(negedge clk_i);
        y = y_o;
    endtask

    initial begin
        logic [127:0] y, y0, y1, y2;
        int tot;
        #20000000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] y, y0, y1, y2, base;
        int tot;
        // R1: reset holds output at zero despite live operands
        a_i = 128'h55;
        b_i = 128'hAA;
        repeat (3) @(negedge clk_i);
        check("R1 reset", y_o, 128'h0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 first edge", y_o, gold(128'h55, 128'hAA));

        // R2 R3 R4 R5: vector table against model
        for (int i = 0; i < NV; i++) begin
            run(VEC[i][255:128], VEC[i][127:0], y);
            check("R2 R3 R4 R5 vector", y, gold(VEC[i][255:128], VEC[i][127:0]));
        end

        // R8: hold
        @(negedge clk_i);
        check("R8 hold", y_o, gold(VEC[NV-1][255:128], VEC[NV-1][127:0]));

        // R5: b enters after mixing; Feistel self-inverse
        run(128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0, 128'h0, y0);
        run(128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0, 128'hCAFE_F00D_1234_5678_9ABC_DEF0_0BAD_F00D, y1);
        check("R5 linear in b", y0 ^ y1, 128'hCAFE_F00D_1234_5678_9ABC_DEF0_0BAD_F00D);
        run(128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0, y1, y2);
        check("R5 feistel", y2, 128'hCAFE_F00D_1234_5678_9ABC_DEF0_0BAD_F00D);

        // R6: lane swap asymmetry
        base = 128'h0000_0000_0000_0001_0000_0000_0000_0001;
        run(base, 128'h0, y0);
        run(swp(128'h1234_5678_9ABC_DEF0_1111_2222_3333_4444), 128'h0, y1);
        run(128'h1234_5678_9ABC_DEF0_1111_2222_3333_4444, 128'h0, y2);
        n_checks++;
        if (y1 === swp(y2)) begin
            n_errors++;
            $display("FAIL R6 swap: actual %h expected not %h", y1, swp(y2));
        end
        run(128'h0, 128'h0, y1);
        check("R6 zero operand", y1, gold(128'h0, 128'h0));

        // R7: avalanche
        base = 128'h3141_5926_5358_9793_2384_6264_3383_2795;
        run(base, 128'h0, y0);
        tot = 0;
        for (int f = 0; f < 16; f++) begin
            int pos;
            int c;
            pos = (f * 37 + 5) % 128;
            run(base ^ (128'h1 << pos), 128'h0, y1);
            c = $countones(y0 ^ y1);
            tot += c;
            n_checks++;
            if (c < 20 || c > 108) begin
                n_errors++;
                $display("FAIL R7 flip bit %0d: actual %0d expected 20..108", pos, c);
            end
        end
        n_checks++;
        if (tot < 52 * 16 || tot > 76 * 16) begin
            n_errors++;
            $display("FAIL R7 average: actual %0d expected %0d..%0d", tot, 52 * 16, 76 * 16);
        end

        // R1: reset mid-run clears output
        @(negedge clk_i);
        rst_ni = 1'b0;
        #1;
        check("R1 async clear", y_o, 128'h0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule